// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block turns four maskable external request pins and one non-maskable pin into request lines for a downstream priority arbiter. All pin inputs are assumed to be already synchronized to the system clock. Each maskable pin has its own sensing mode. In low-level mode the request follows the pin as it changes. In the two edge modes a detected transition is latched and held until the arbiter acknowledges it or software withdraws it. The non-maskable pin is always edge sensed, and one polarity bit selects whether the rising or the falling edge counts.

Software reaches the block through a small register bus with three registers: the sensing modes, the non-maskable polarity, and the per-pin status flags. A latched edge flag can only be withdrawn in two steps. Software first reads the flag as 1, then writes 0 to it. If a new edge arrives in the same cycle as a clear, the edge wins. The request/acknowledge pairs are plain level signals. There is no data stream, so there is no back-pressure: an acknowledge takes effect on the next clock edge whenever it is seen, and it is ignored when nothing is latched.

Top module: `ext_irq_detect`

## Requirements
- R1: The mode register at address 0 holds 2 bits per maskable pin, in bits [2i+1:2i] for pin i. The codes are 00 = low level, 01 = falling edge, 10 = rising edge and 11 = falling edge. The register reads back as written.
- R2: In low-level mode, irq_req[i] is high in exactly those cycles in which irq_pin[i] is low, with no register in the path. Status bit i shows the same live value, and writes to the status register do not change it.
- R3: In an edge mode, the selected transition sets irq_req[i] at the clock edge that samples the new pin level. The request then stays high, while the pin returns or stays, until it is cleared. A transition of the other direction never sets it.
- R4: A one-cycle pulse on irq_ack[i] clears a latched edge request at the next clock edge.
- R5: The status register at address 2 shows flag i in bit i. Read data on bus_rdata appears one cycle after the bus_rd strobe and holds until the next read.
- R6: Writing 0 to status bit i clears a latched edge flag only if that flag was read as 1 since it was last set. A write of 0 without that read has no effect, and a write of 1 never sets a flag.
- R7: If a new edge arrives in the same cycle as an acknowledge or a software clear, the flag stays set.
- R8: nmi_req latches on the nmi_pin edge selected by bit 0 of address 1 (0 = falling, 1 = rising). It holds until nmi_ack clears it, and a new edge in the cycle of nmi_ack keeps it set.
- R9: After reset every request is low, the mode register and the polarity bit are 0, and the stored previous pin samples are high. Pins that are held high therefore create no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | NUM_PINS | Synchronized maskable request pins |
| nmi_pin | input | 1 | Synchronized non-maskable pin |
| irq_ack | input | NUM_PINS | Arbiter acknowledge, one per pin |
| nmi_ack | input | 1 | Arbiter acknowledge for the non-maskable request |
| irq_req | output | NUM_PINS | Request lines to the arbiter |
| nmi_req | output | 1 | Non-maskable request line |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block with its defaults: four maskable pins and a 16-bit data bus. With four pins, every mode code, including the alias code 11, is active on a different pin at the same time from one mode-register write. The 16-bit bus is wide enough that a status write can carry 1s for the bystander pins while it withdraws a single flag. This isolates the read-then-clear rule to one pin, and it exposes the collision of an edge with an acknowledge and a software clear in the same cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW      = 2'b00,
    SENSE_FALL     = 2'b01,
    SENSE_RISE     = 2'b10,
    SENSE_FALL_ALT = 2'b11
  } sense_e;

  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_NMI  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/eid_pin_sense.sv
module eid_pin_sense
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  input  logic       ack,
  input  logic       flag_rd,
  input  logic       flag_wr,
  input  logic       wr_bit,
  output logic       req
);
  logic prev_q, latch_q, arm_q;
  logic is_level, want_rise, hit, sw_clr;

  assign is_level  = (mode == SENSE_LOW);
  assign want_rise = (mode == SENSE_RISE);
  assign hit       = !is_level && (want_rise ? (!prev_q && pin) : (prev_q && !pin));
  assign sw_clr    = flag_wr && !wr_bit && arm_q;
  assign req       = is_level ? !pin : latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      prev_q <= pin;
      if (is_level) begin
        latch_q <= 1'b0;
        arm_q   <= 1'b0;
      end else if (hit) begin
        latch_q <= 1'b1;
        arm_q   <= 1'b0;
      end else if (ack || sw_clr) begin
        latch_q <= 1'b0;
        arm_q   <= 1'b0;
      end else if (flag_rd && latch_q) begin
        arm_q <= 1'b1;
      end
    end
  end

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && req && !ack && !sw_clr) |=> (req || is_level));
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && !req && !hit) |=> (!req || is_level));
  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && ack && !hit) |=> (!req || is_level));
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && hit) |=> (req || is_level));
endmodule

// File: rtl/eid_nmi_sense.sv
module eid_nmi_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic ack,
  output logic req
);
  logic prev_q, req_q, hit;

  assign hit = rise_sel ? (!prev_q && pin) : (prev_q && !pin);
  assign req = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      prev_q <= pin;
      if (hit)      req_q <= 1'b1;
      else if (ack) req_q <= 1'b0;
    end
  end

  assert_nmi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  assert_nmi_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !req);
endmodule

// File: rtl/eid_regs.sv
module eid_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [NUM_PINS-1:0]   flags,
  output logic [2*NUM_PINS-1:0] mode_q,
  output logic                  nmi_rise_q,
  output logic                  flag_rd,
  output logic                  flag_wr,
  output logic [NUM_PINS-1:0]   wr_bits,
  output logic [DATA_W-1:0]     bus_rdata
);
  localparam int MODE_W = 2 * NUM_PINS;

  logic [DATA_W-1:0] rd_mux;

  assign flag_rd = bus_rd && (bus_addr == ADDR_FLAG);
  assign flag_wr = bus_wr && (bus_addr == ADDR_FLAG);
  assign wr_bits = bus_wdata[NUM_PINS-1:0];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_MODE: rd_mux[MODE_W-1:0]   = mode_q;
      ADDR_NMI:  rd_mux[0]            = nmi_rise_q;
      ADDR_FLAG: rd_mux[NUM_PINS-1:0] = flags;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      nmi_rise_q <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_MODE) mode_q     <= bus_wdata[MODE_W-1:0];
      if (bus_wr && bus_addr == ADDR_NMI)  nmi_rise_q <= bus_wdata[0];
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   irq_pin,
  input  logic                  nmi_pin,
  input  logic [NUM_PINS-1:0]   irq_ack,
  input  logic                  nmi_ack,
  output logic [NUM_PINS-1:0]   irq_req,
  output logic                  nmi_req,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata
);
  logic [2*NUM_PINS-1:0] mode_q;
  logic                  nmi_rise_q;
  logic                  flag_rd, flag_wr;
  logic [NUM_PINS-1:0]   wr_bits;

  eid_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .flags      (irq_req),
    .mode_q     (mode_q),
    .nmi_rise_q (nmi_rise_q),
    .flag_rd    (flag_rd),
    .flag_wr    (flag_wr),
    .wr_bits    (wr_bits),
    .bus_rdata  (bus_rdata)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    eid_pin_sense u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (irq_pin[i]),
      .mode    (mode_q[2*i+1:2*i]),
      .ack     (irq_ack[i]),
      .flag_rd (flag_rd),
      .flag_wr (flag_wr),
      .wr_bit  (wr_bits[i]),
      .req     (irq_req[i])
    );
  end

  eid_nmi_sense u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (nmi_pin),
    .rise_sel (nmi_rise_q),
    .ack      (nmi_ack),
    .req      (nmi_req)
  );
endmodule

// File: tb/ext_irq_detect_bench.sv
module ext_irq_detect_bench;
  localparam int N = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_pin = '1;
  logic nmi_pin = 1'b1;
  logic [N-1:0] irq_ack = '0;
  logic nmi_ack = 1'b0;
  logic [N-1:0] irq_req;
  logic nmi_req;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ext_irq_detect #(.NUM_PINS(N), .DATA_W(DW)) u_ext_irq_detect (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
    .irq_ack(irq_ack), .nmi_ack(nmi_ack), .irq_req(irq_req), .nmi_req(nmi_req),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R9 irq_req after reset", 32'(irq_req), 0);
    check("R9 nmi_req after reset", 32'(nmi_req), 0);
    rd(2'd0, d); check("R9 mode reg reset", 32'(d), 0);
    rd(2'd1, d); check("R9 polarity reset", 32'(d), 0);
  endtask

  task automatic t_level();
    logic [DW-1:0] d;
    irq_pin[0] = 1'b0; #1;
    check("R2 level req same cycle", 32'(irq_req[0]), 1);
    rd(2'd2, d); check("R2 R5 level flag reads live", 32'(d[0]), 1);
    wr(2'd2, 16'hFFFE); #1;
    check("R2 write 0 ignored in level mode", 32'(irq_req[0]), 1);
    irq_pin[0] = 1'b1; #1;
    check("R2 level req drops with pin", 32'(irq_req[0]), 0);
    tick();
  endtask

  task automatic t_modes();
    logic [DW-1:0] d;
    wr(2'd0, 16'h00E4);
    rd(2'd0, d); check("R1 mode readback", 32'(d), 32'hE4);
    irq_pin[1] = 1'b0; tick(); #1;
    check("R3 falling edge latches", 32'(irq_req[1]), 1);
    irq_pin[1] = 1'b1; repeat (3) tick(); #1;
    check("R3 latched after pin returns", 32'(irq_req[1]), 1);
    irq_pin[2] = 1'b0; tick(); #1;
    check("R3 rising mode ignores fall", 32'(irq_req[2]), 0);
    irq_pin[2] = 1'b1; tick(); #1;
    check("R3 rising edge latches", 32'(irq_req[2]), 1);
    irq_pin[3] = 1'b0; tick(); #1;
    check("R1 code 11 acts as falling", 32'(irq_req[3]), 1);
    irq_pin[3] = 1'b1; tick();
  endtask

  task automatic t_ack();
    irq_ack[1] = 1'b1; tick(); irq_ack[1] = 1'b0; #1;
    check("R4 ack clears pin1", 32'(irq_req[1]), 0);
    irq_ack[3] = 1'b1; tick(); irq_ack[3] = 1'b0; #1;
    check("R4 ack clears pin3", 32'(irq_req[3]), 0);
  endtask

  task automatic t_swclear();
    logic [DW-1:0] d;
    wr(2'd2, 16'hFFFB); #1;
    check("R6 write 0 without read ignored", 32'(irq_req[2]), 1);
    wr(2'd2, 16'hFFFF); #1;
    check("R6 write 1 does not set pin3", 32'(irq_req[3]), 0);
    rd(2'd2, d); check("R5 status shows pin2 flag", 32'(d[3:1]), 32'b010);
    wr(2'd2, 16'hFFFB); #1;
    check("R6 read then write 0 clears", 32'(irq_req[2]), 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    irq_pin[1] = 1'b0; tick(); irq_pin[1] = 1'b1; tick();
    rd(2'd2, d); check("R5 pin1 flag read", 32'(d[1]), 1);
    irq_pin[1] = 1'b0; irq_ack[1] = 1'b1;
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'hFFFD;
    tick();
    irq_ack[1] = 1'b0; bus_wr = 1'b0; #1;
    check("R7 edge beats ack and clear", 32'(irq_req[1]), 1);
    irq_pin[1] = 1'b1;
    irq_ack[1] = 1'b1; tick(); irq_ack[1] = 1'b0; #1;
    check("R4 ack after collision", 32'(irq_req[1]), 0);
  endtask

  task automatic t_nmi();
    logic [DW-1:0] d;
    nmi_pin = 1'b0; tick(); #1;
    check("R8 nmi falling latches", 32'(nmi_req), 1);
    nmi_pin = 1'b1; tick(); #1;
    check("R8 nmi held", 32'(nmi_req), 1);
    nmi_ack = 1'b1; tick(); nmi_ack = 1'b0; #1;
    check("R8 nmi ack clears", 32'(nmi_req), 0);
    wr(2'd1, 16'h0001);
    rd(2'd1, d); check("R8 polarity readback", 32'(d), 1);
    nmi_pin = 1'b0; tick(); #1;
    check("R8 rising mode ignores fall", 32'(nmi_req), 0);
    nmi_pin = 1'b1; nmi_ack = 1'b1; tick(); nmi_ack = 1'b0; #1;
    check("R8 rising edge wins over ack", 32'(nmi_req), 1);
    nmi_ack = 1'b1; tick(); nmi_ack = 1'b0; #1;
    check("R8 nmi ack clears again", 32'(nmi_req), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_level();
    t_modes();
    t_ack();
    t_swclear();
    t_collide();
    t_nmi();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule